// File: doc/BRIEF.md
# USB Remote Wakeup Sequencer

This block steps a USB device out of suspend when software asks for a remote wakeup. It sits between the device controller and a UTMI-style PHY and runs on an always-on slow clock that carries a one-millisecond tick. It watches the controller's active-low suspend indication and records the link speed mode on suspend entry. It then makes the device stay suspended for a minimum time before a wakeup may start.

When a wakeup request is accepted, the sequencer raises the controller's wakeup input while the PHY is still asleep. On the next cycle it lets the PHY leave suspend, so that the PHY clock to the controller restarts. It keeps wakeup high until the clock-present indication comes back. It then times the device-driven K interval and waits for the host resume to end in SE0.

A clock that never returns raises a sticky error flag and sends the sequencer back to the suspended wait. So does a host resume that never ends. Inputs from the stopped domain pass through multi-stage synchronizers. The current state, a one-cycle completion pulse and the speed mode recorded at suspend entry are visible at the ports.

Top module: `usb_rwake_seq`

## Requirements
- R1: After reset, seq_state is 0, ctrl_wakeup is 0, phy_sleep_n is 1, wake_done is 0 and wake_err is 0.
- R2: In state 0, a synchronized low on ctrl_suspend_n moves the sequencer to state 1. It drives phy_sleep_n low and records the synchronized ctrl_hs_mode into speed_hs.
- R3: State 1 moves to state 2 on the third tick_ms pulse counted in state 1 (SUSP_MIN_MS+1 ticks, which covers a partial first millisecond). ctrl_wakeup stays 0 until then.
- R4: A wake_req pulse in state 1 is held pending and acted on when state 2 is reached. A pulse in state 2 is acted on at once. A pulse in state 0 is ignored.
- R5: A synchronized high on ctrl_suspend_n in state 1 or 2 returns the sequencer to state 0 and drops any pending request.
- R6: Accepting a wakeup gives one cycle of state 3, with ctrl_wakeup 1 and phy_sleep_n 0. State 4 follows, with ctrl_wakeup 1 and phy_sleep_n 1. A high on ctrl_suspend_n during state 4 has no effect.
- R7: ctrl_wakeup stays 1 in state 4 until the synchronized phy_clk_ok is high. The sequencer then enters state 5 with ctrl_wakeup 0.
- R8: If phy_clk_ok does not arrive by the cfg_clk_to_ms-th tick in state 4, wake_err is set, the sequencer returns to state 1 and ctrl_wakeup falls.
- R9: State 5 lasts DEV_K_MS (2) ticks and then moves to state 6.
- R10: State 6 completes only when phy_line_state is SE0 (2'b00) and at least HOST_MIN_MS (20) ticks have been counted in it. An earlier SE0 waits for that count. On completion, state 7 lasts one cycle with wake_done 1, then state 0.
- R11: If state 6 reaches HOST_MAX_MS (40) ticks without completing, wake_err is set and the sequencer returns to state 1.
- R12: speed_hs keeps the value recorded at suspend entry until the next suspend entry, whatever ctrl_hs_mode does meanwhile.
- R13: wake_err stays set until the sequencer next enters state 3 or is reset.
- R14: seq_state encodes idle 0, suspended wait 1, armed 2, wake assert 3, clock wait 4, device resume 5, host resume 6, done 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond, synchronous to clk |
| ctrl_suspend_n | input | 1 | Controller suspend indication, active low, asynchronous |
| ctrl_hs_mode | input | 1 | Controller speed mode (1 = high speed), asynchronous |
| phy_clk_ok | input | 1 | PHY clock-present indication, asynchronous |
| phy_line_state | input | 2 | Line state from the PHY (00 = SE0, 01 = J, 10 = K), asynchronous |
| wake_req | input | 1 | Software wakeup request pulse, synchronous to clk |
| cfg_clk_to_ms | input | CNT_W | Clock-return timeout in ticks |
| ctrl_wakeup | output | 1 | Wakeup input to the controller |
| phy_sleep_n | output | 1 | PHY suspend control, active low (0 = PHY suspended) |
| speed_hs | output | 1 | Speed mode recorded at suspend entry |
| wake_done | output | 1 | One-cycle pulse when the wakeup completes |
| wake_err | output | 1 | Sticky error flag: clock or host resume timeout |
| seq_state | output | 3 | Current sequencer state |

## Verification
A wrong state shows at seq_state within two or three cycles of the input or tick that should have moved it, and at ctrl_wakeup or phy_sleep_n in the same cycle. An interval counter that is off by one shows as a transition one tick early or late. The bench counts ticks per state to catch this. A lost pending request or a missed clear of the error flag only shows on the next wakeup attempt. The bench therefore runs several attempts in sequence, so that one attempt exposes what the previous one left behind.

// File: rtl/usb_rwake_pkg.sv
// Package: shared state encoding and line-state codes for the remote wakeup
// sequencer. Assumes a 2-bit line state of the usual full-speed form.
package usb_rwake_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        RW_IDLE      = 3'd0,
        RW_SUSP_WAIT = 3'd1,
        RW_ARMED     = 3'd2,
        RW_WAKE      = 3'd3,
        RW_CLK_WAIT  = 3'd4,
        RW_DEV_K     = 3'd5,
        RW_HOST_K    = 3'd6,
        RW_DONE      = 3'd7
    } rw_state_e;

    localparam logic [1:0] LINE_SE0 = 2'b00;

endpackage

// File: rtl/rwake_sync.sv
// Module: multi-stage synchronizer for a bus of independent single-bit
// signals arriving from a domain whose clock may be stopped. Assumes each
// bit is quasi-static relative to clk (no multi-bit coherence is needed).
module rwake_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d;
                end
            end else begin : g_rest
                // pass the value one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rwake_tick_timer.sv
// Module: counts millisecond ticks since the last clear and saturates at the
// counter maximum. Assumes tick is a one-cycle pulse in the clk domain. A
// clear wins over a tick in the same cycle.
module rwake_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // count ticks, restarting whenever the sequencer changes state
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rwake_fsm.sv
// Module: the remote wakeup state machine. It takes the synchronized
// controller and PHY indications and the tick count of the current state.
// It decides the transitions, holds a pending request, records the speed
// mode and the sticky error, and decodes the drive outputs from the state.
// Assumes wake_req and tick arrive in the clk domain.
module rwake_fsm
    import usb_rwake_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SUSP_MIN_MS = 2,
    parameter int DEV_K_MS    = 2,
    parameter int HOST_MIN_MS = 20,
    parameter int HOST_MAX_MS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                susp_n_s,
    input  logic                clk_ok_s,
    input  logic                se0_s,
    input  logic                hs_s,
    input  logic                wake_req,
    input  logic [CNT_W-1:0]    cfg_clk_to,
    input  logic [CNT_W-1:0]    cnt,
    output logic                tmr_clr,
    output logic [STATE_W-1:0]  st_o,
    output logic                wakeup_o,
    output logic                sleep_n_o,
    output logic                done_o,
    output logic                err_o,
    output logic                speed_o
);

    localparam logic [CNT_W:0] SUSP_TICKS = (CNT_W+1)'(SUSP_MIN_MS + 1);
    localparam logic [CNT_W:0] DEV_TICKS  = (CNT_W+1)'(DEV_K_MS);
    localparam logic [CNT_W:0] HOST_MIN   = (CNT_W+1)'(HOST_MIN_MS);
    localparam logic [CNT_W:0] HOST_MAX   = (CNT_W+1)'(HOST_MAX_MS);

    rw_state_e   st, nxt;
    logic        pend_q;
    logic        err_q;
    logic        speed_q;
    logic [CNT_W:0] cnt_next;
    logic        go_wake;
    logic        to_err;

    // tick count the state would hold after this cycle's tick
    assign cnt_next = {1'b0, cnt} + (CNT_W+1)'(1);

    // a request is taken when armed, either held from before or fresh
    assign go_wake = pend_q || wake_req;

    // choose the next state and whether a timeout is being taken
    always_comb begin
        nxt    = st;
        to_err = 1'b0;
        unique case (st)
            RW_IDLE: begin
                if (!susp_n_s) nxt = RW_SUSP_WAIT;
            end
            RW_SUSP_WAIT: begin
                if (susp_n_s)                        nxt = RW_IDLE;
                else if (tick && cnt_next >= SUSP_TICKS) nxt = RW_ARMED;
            end
            RW_ARMED: begin
                if (susp_n_s)     nxt = RW_IDLE;
                else if (go_wake) nxt = RW_WAKE;
            end
            RW_WAKE: begin
                nxt = RW_CLK_WAIT;
            end
            RW_CLK_WAIT: begin
                if (clk_ok_s) begin
                    nxt = RW_DEV_K;
                end else if (tick && cnt_next >= {1'b0, cfg_clk_to}) begin
                    nxt    = RW_SUSP_WAIT;
                    to_err = 1'b1;
                end
            end
            RW_DEV_K: begin
                if (tick && cnt_next >= DEV_TICKS) nxt = RW_HOST_K;
            end
            RW_HOST_K: begin
                if (se0_s && {1'b0, cnt} >= HOST_MIN) begin
                    nxt = RW_DONE;
                end else if (tick && cnt_next >= HOST_MAX) begin
                    nxt    = RW_SUSP_WAIT;
                    to_err = 1'b1;
                end
            end
            RW_DONE: begin
                nxt = RW_IDLE;
            end
            default: nxt = RW_IDLE;
        endcase
    end

    // restart the interval timer on every state change
    assign tmr_clr = (nxt != st);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= RW_IDLE;
        else        st <= nxt;
    end

    // hold an early request until armed; drop it on leaving suspend or on use
    always_ff @(posedge clk) begin
        if (!rst_n)                                pend_q <= 1'b0;
        else if (nxt == RW_IDLE || nxt == RW_WAKE) pend_q <= 1'b0;
        else if (st == RW_SUSP_WAIT && wake_req)   pend_q <= 1'b1;
    end

    // sticky error: set by a timeout, cleared by the next wakeup attempt
    always_ff @(posedge clk) begin
        if (!rst_n)               err_q <= 1'b0;
        else if (to_err)          err_q <= 1'b1;
        else if (nxt == RW_WAKE)  err_q <= 1'b0;
    end

    // record the link speed mode at suspend entry
    always_ff @(posedge clk) begin
        if (!rst_n)                                speed_q <= 1'b0;
        else if (st == RW_IDLE && nxt == RW_SUSP_WAIT) speed_q <= hs_s;
    end

    // decode the drive outputs from the state
    always_comb begin
        wakeup_o  = (st == RW_WAKE) || (st == RW_CLK_WAIT);
        sleep_n_o = !((st == RW_SUSP_WAIT) || (st == RW_ARMED) || (st == RW_WAKE));
        done_o    = (st == RW_DONE);
    end

    assign st_o    = st;
    assign err_o   = err_q;
    assign speed_o = speed_q;

endmodule

// File: rtl/usb_rwake_seq.sv
// Module: top of the remote wakeup sequencer. It synchronizes the inputs
// from the possibly stopped controller/PHY domain, then feeds the state
// machine and its tick timer. Assumes clk and tick_ms run during suspend.
module usb_rwake_seq
    import usb_rwake_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SUSP_MIN_MS = 2,
    parameter int DEV_K_MS    = 2,
    parameter int HOST_MIN_MS = 20,
    parameter int HOST_MAX_MS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             ctrl_suspend_n,
    input  logic             ctrl_hs_mode,
    input  logic             phy_clk_ok,
    input  logic [1:0]       phy_line_state,
    input  logic             wake_req,
    input  logic [CNT_W-1:0] cfg_clk_to_ms,
    output logic             ctrl_wakeup,
    output logic             phy_sleep_n,
    output logic             speed_hs,
    output logic             wake_done,
    output logic             wake_err,
    output logic [2:0]       seq_state
);

    localparam int SYNC_W = 5;
    localparam logic [SYNC_W-1:0] SYNC_RST = 5'b0_0001;

    logic [SYNC_W-1:0] async_in;
    logic [SYNC_W-1:0] sync_out;
    logic              susp_n_s;
    logic              hs_s;
    logic              clk_ok_s;
    logic [1:0]        line_s;
    logic              se0_s;
    logic              tmr_clr;
    logic [CNT_W-1:0]  tmr_cnt;

    // gather the stopped-domain inputs; suspend indication idles high
    assign async_in = {phy_line_state, phy_clk_ok, ctrl_hs_mode, ctrl_suspend_n};

    rwake_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (async_in),
        .q    (sync_out)
    );

    assign susp_n_s = sync_out[0];
    assign hs_s     = sync_out[1];
    assign clk_ok_s = sync_out[2];
    assign line_s   = sync_out[4:3];
    assign se0_s    = (line_s == LINE_SE0);

    rwake_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick_ms),
        .cnt  (tmr_cnt)
    );

    rwake_fsm #(
        .CNT_W      (CNT_W),
        .SUSP_MIN_MS(SUSP_MIN_MS),
        .DEV_K_MS   (DEV_K_MS),
        .HOST_MIN_MS(HOST_MIN_MS),
        .HOST_MAX_MS(HOST_MAX_MS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .susp_n_s  (susp_n_s),
        .clk_ok_s  (clk_ok_s),
        .se0_s     (se0_s),
        .hs_s      (hs_s),
        .wake_req  (wake_req),
        .cfg_clk_to(cfg_clk_to_ms),
        .cnt       (tmr_cnt),
        .tmr_clr   (tmr_clr),
        .st_o      (seq_state),
        .wakeup_o  (ctrl_wakeup),
        .sleep_n_o (phy_sleep_n),
        .done_o    (wake_done),
        .err_o     (wake_err),
        .speed_o   (speed_hs)
    );

endmodule

// File: rtl/rwake_checker.sv
// Module: assertion checker for the remote wakeup sequencer, attached to the
// top by the bind statement below. Observes ports and synchronized inputs.
module rwake_checker
    import usb_rwake_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic [2:0] seq_state,
    input logic       ctrl_wakeup,
    input logic       phy_sleep_n,
    input logic       wake_done,
    input logic       wake_err,
    input logic       speed_hs,
    input logic       clk_ok_s,
    input logic       se0_s
);

    // arming only happens on a tick
    assert_arm_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == RW_ARMED && $past(seq_state) == RW_SUSP_WAIT) |-> $past(tick_ms));

    // wakeup starts with the PHY still asleep
    assert_wake_phy_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == RW_WAKE && $past(seq_state) != RW_WAKE) |-> (ctrl_wakeup && !phy_sleep_n));

    // entering clock wait releases the PHY while wakeup remains high
    assert_phy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == RW_CLK_WAIT && $past(seq_state) == RW_WAKE) |-> (ctrl_wakeup && phy_sleep_n));

    // wakeup only drops toward device resume once the clock is seen
    assert_hold_until_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == RW_DEV_K && $past(seq_state) == RW_CLK_WAIT) |-> $past(clk_ok_s));

    // completion needs SE0 and is a single cycle
    assert_done_on_se0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_done) |-> $past(se0_s));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // the error flag rises only together with a return to suspended wait
    assert_err_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_err) |-> (seq_state == RW_SUSP_WAIT));

    // the recorded speed only changes on leaving idle
    assert_speed_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_state) != RW_IDLE) |-> $stable(speed_hs));

endmodule

bind usb_rwake_seq rwake_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .seq_state  (seq_state),
    .ctrl_wakeup(ctrl_wakeup),
    .phy_sleep_n(phy_sleep_n),
    .wake_done  (wake_done),
    .wake_err   (wake_err),
    .speed_hs   (speed_hs),
    .clk_ok_s   (clk_ok_s),
    .se0_s      (se0_s)
);

// File: tb/sim_usb_rwake_seq.sv
// Bench: a table of wakeup scenarios walked by one loop, then directed tests
// for reset, request handling, suspend exit and error clearing.
module sim_usb_rwake_seq;

    localparam int CNT_W     = 8;
    localparam int HOST_MIN  = 20;
    localparam int HOST_MAX  = 40;
    localparam int CLK_TO    = 5;
    localparam int NVEC      = 5;

    // vector: {hs, clk_ticks, host_ticks}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 8'd0, 8'd25},
        {1'b0, 8'd3, 8'd5},
        {1'b1, 8'd7, 8'd0},
        {1'b0, 8'd1, 8'd45},
        {1'b1, 8'd4, 8'd20}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_ms = 1'b0;
    logic             ctrl_suspend_n = 1'b1;
    logic             ctrl_hs_mode = 1'b0;
    logic             phy_clk_ok = 1'b0;
    logic [1:0]       phy_line_state = 2'b01;
    logic             wake_req = 1'b0;
    logic [CNT_W-1:0] cfg_clk_to_ms = CNT_W'(CLK_TO);
    logic             ctrl_wakeup, phy_sleep_n, speed_hs, wake_done, wake_err;
    logic [2:0]       seq_state;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    usb_rwake_seq u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_ms       (tick_ms),
        .ctrl_suspend_n(ctrl_suspend_n),
        .ctrl_hs_mode  (ctrl_hs_mode),
        .phy_clk_ok    (phy_clk_ok),
        .phy_line_state(phy_line_state),
        .wake_req      (wake_req),
        .cfg_clk_to_ms (cfg_clk_to_ms),
        .ctrl_wakeup   (ctrl_wakeup),
        .phy_sleep_n   (phy_sleep_n),
        .speed_hs      (speed_hs),
        .wake_done     (wake_done),
        .wake_err      (wake_err),
        .seq_state     (seq_state)
    );

    // count completion pulses away from the active edge
    always @(negedge clk) if (rst_n && wake_done) done_cnt++;

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick;
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        waitn(3);
    endtask

    task automatic pulse_req;
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk) rst_n = 1'b0;
        ctrl_suspend_n = 1'b1;
        phy_clk_ok     = 1'b0;
        phy_line_state = 2'b01;
        wake_req       = 1'b0;
        tick_ms        = 1'b0;
        cfg_clk_to_ms  = CNT_W'(CLK_TO);
        waitn(4);
        rst_n = 1'b1;
        waitn(2);
    endtask

    task automatic enter_suspend(input logic hs);
        ctrl_hs_mode   = hs;
        ctrl_suspend_n = 1'b0;
        waitn(5);
    endtask

    initial begin
        do_reset();

        // R1, R14: reset state
        chk("R1 state", seq_state, 0);
        chk("R1 wakeup", ctrl_wakeup, 0);
        chk("R1 sleep_n", phy_sleep_n, 1);
        chk("R1 done", wake_done, 0);
        chk("R1 err", wake_err, 0);

        // table of full wakeup scenarios
        for (int v = 0; v < NVEC; v++) begin
            logic hs;
            int   clk_t, host_t, n, exp_n, d0;
            hs     = VEC[v][16];
            clk_t  = int'(VEC[v][15:8]);
            host_t = int'(VEC[v][7:0]);
            d0     = done_cnt;

            enter_suspend(hs);
            chk("R2 enter", seq_state, 1);
            chk("R2 sleep_n", phy_sleep_n, 0);
            chk("R2 speed", speed_hs, int'(hs));
            ctrl_hs_mode = ~hs;               // must not disturb the record (R12)

            pulse_req();                      // early request, held pending (R4)
            pulse_tick();
            pulse_tick();
            chk("R3 dwell state", seq_state, 1);
            chk("R3 no early wakeup", ctrl_wakeup, 0);
            pulse_tick();
            chk("R4 pending acted", seq_state, 4);
            chk("R6 wakeup", ctrl_wakeup, 1);
            chk("R6 sleep_n", phy_sleep_n, 1);

            if (clk_t < CLK_TO) begin
                ctrl_suspend_n = 1'b1;        // controller leaves suspend (R6)
                waitn(5);
                chk("R6 suspend_n ignored", seq_state, 4);
                for (int k = 0; k < clk_t; k++) pulse_tick();
                chk("R7 held", ctrl_wakeup, 1);
                phy_clk_ok     = 1'b1;
                phy_line_state = 2'b10;
                waitn(5);
                chk("R7 dev resume", seq_state, 5);
                chk("R7 wakeup off", ctrl_wakeup, 0);
                n = 0;
                while (seq_state == 5 && n < 10) begin pulse_tick(); n++; end
                chk("R9 dev ticks", n, 2);
                chk("R9 host state", seq_state, 6);
                n = 0;
                while (seq_state == 6 && n < 60) begin
                    if (n == host_t) begin
                        phy_line_state = 2'b00;
                        waitn(6);
                        if (seq_state != 6) break;
                    end
                    pulse_tick();
                    n++;
                end
                if (host_t >= HOST_MAX) begin
                    chk("R11 host ticks", n, HOST_MAX);
                    chk("R11 err", wake_err, 1);
                    chk("R11 no done", done_cnt - d0, 0);
                end else begin
                    exp_n = (host_t > HOST_MIN) ? host_t : HOST_MIN;
                    chk("R10 host ticks", n, exp_n);
                    chk("R10 done pulses", done_cnt - d0, 1);
                    chk("R10 back idle", seq_state, 0);
                    chk("R12 speed", speed_hs, int'(hs));
                end
            end else begin
                n = 0;
                while (seq_state == 4 && n < 20) begin pulse_tick(); n++; end
                chk("R8 timeout ticks", n, CLK_TO);
                chk("R8 state", seq_state, 1);
                chk("R8 err", wake_err, 1);
                chk("R8 wakeup off", ctrl_wakeup, 0);
            end

            // return to idle for the next scenario
            ctrl_suspend_n = 1'b1;
            phy_clk_ok     = 1'b0;
            phy_line_state = 2'b01;
            waitn(8);
            chk("R5 cleanup idle", seq_state, 0);
        end

        // R4: request in idle ignored, request in armed acted on at once
        do_reset();
        pulse_req();
        enter_suspend(1'b0);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R4 idle req ignored", seq_state, 2);
        chk("R4 armed no wakeup", ctrl_wakeup, 0);
        pulse_req();
        waitn(3);
        chk("R4 armed req", seq_state, 4);

        // R8 boundary: timeout of one tick; R13 sticky error
        cfg_clk_to_ms = CNT_W'(1);
        pulse_tick();
        chk("R8 one tick timeout", seq_state, 1);
        chk("R13 err set", wake_err, 1);
        pulse_tick(); pulse_tick();
        chk("R13 err sticky", wake_err, 1);
        pulse_tick();
        chk("R13 rearmed", seq_state, 2);
        pulse_req();
        waitn(2);
        chk("R13 err cleared", wake_err, 0);

        // R5: leaving suspend while waiting drops the pending request
        do_reset();
        enter_suspend(1'b1);
        pulse_req();
        ctrl_suspend_n = 1'b1;
        waitn(5);
        chk("R5 to idle", seq_state, 0);
        chk("R5 sleep_n", phy_sleep_n, 1);
        enter_suspend(1'b0);
        chk("R12 new record", speed_hs, 0);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R5 pending dropped", seq_state, 2);
        ctrl_suspend_n = 1'b1;
        waitn(5);
        chk("R5 armed to idle", seq_state, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule